// File: doc/BRIEF.md
# Slave Port Arbiter with Parking

This block decides which of eight bus masters owns one slave port of a multi-master crossbar. Each master raises a request line. The arbiter answers with a one-hot grant vector, the encoded index of the owner and a valid flag. Two run-time registers configure it. The priority word gives every master a level. The control word selects the arbitration style and the parking policy, and it carries a lock bit.

Ownership is registered, so a new owner takes the port one clock after it is chosen. While the owner signals that a transfer is in progress, the grant does not move. The arbiter looks at the requests again only on a cycle where that signal is low. When nobody requests, the port is parked. It can be parked on a programmed master, on the most recent winner, or on no master at all. A parked master already holds the port when its own request arrives. Software reads and writes the two registers through a single-cycle select and write-enable interface, and reads are combinational.

Top module: `slave_port_arbiter`

## Requirements
- R1: `reg_sel`=0 selects the priority word and `reg_sel`=1 selects the control word. `reg_rdata` shows the selected word in the same cycle. Master m's level sits in bits [4m+2:4m] of the priority word. After reset the priority word is 0x76543210, so master m has level m and master 7 is masked. After reset the control word is 0.
- R2: Writes keep only the defined bits. The priority mask is 0x77777777 and the control mask is 0x80000137. All other bits read back as zero.
- R3: Control bit 31 is a lock. While it is 1, every write to either register is ignored. The lock stays set until reset.
- R4: With control bit 8 = 0 (fixed mode), the winner is the requester with the numerically lowest level. On equal levels, the lower master index wins.
- R5: A master whose level field holds 7 is never granted, in either mode.
- R6: With control bit 8 = 1 (round-robin mode), the search starts one index after the last arbitration winner and wraps from 7 to 0. After reset the last winner is taken to be master 7.
- R7: While `gnt_valid` and `xfer_busy` are both 1, the grant does not change on the next edge, whatever the requests are.
- R8: An arbitration winner owns the port from the clock edge after the cycle in which it won. A master that already holds the parked grant is served with no extra cycle. Switching to another master costs exactly one cycle.
- R9: When no eligible master requests and control bits 5:4 = 00, the port parks on the master in control bits 2:0. After reset it is parked on master 0.
- R10: When no eligible master requests and control bits 5:4 = 01, the port parks on the last arbitration winner.
- R11: When no eligible master requests and control bits 5:4 are 10 or 11, no master is granted. In that case `gnt` = 0, `gnt_idx` = 0 and `gnt_valid` = 0.
- R12: `gnt` has at most one bit set. That bit equals `gnt_idx`, and it is set exactly when `gnt_valid` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 8 | Request line of each master |
| xfer_busy | input | 1 | The owner's transfer is still in progress |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the priority word, 1 selects the control word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| gnt | output | 8 | One-hot grant |
| gnt_idx | output | 3 | Index of the granted master |
| gnt_valid | output | 1 | A master owns the port |

## Verification
A corrupted owner register or winner register shows at the grant outputs on the very next edge. The grant then moves to the wrong master. Other symptoms are a round-robin sequence that rotates from the wrong starting point, or an idle port that parks somewhere unexpected. A wrong register value shows up at once on a combinational read. It also shows in the first arbitration decision that uses the bad level or mode bit. A lock that fails shows as a read-back change after a blocked write. To catch these, every request pattern is swept in both modes against a cycle-accurate model in the bench. The outputs are compared on every cycle, so any divergence is reported one cycle after it is caused.

// File: rtl/spa_pkg.sv
`timescale 1ns/1ps
package spa_pkg;
  // Control word fields whose positions software relies on
  localparam int unsigned LOCK_POS      = 31;
  localparam int unsigned MODE_POS      = 8;
  localparam int unsigned PARK_MODE_POS = 4;
  localparam int unsigned PARK_IDX_POS  = 0;

  typedef enum logic [1:0] {
    PARK_ON_FIXED = 2'b00,
    PARK_ON_LAST  = 2'b01,
    PARK_NONE     = 2'b10,
    PARK_NONE_ALT = 2'b11
  } park_mode_e;

  typedef enum logic {
    SEL_PRIO = 1'b0,
    SEL_CTRL = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/spa_regs.sv
`timescale 1ns/1ps
module spa_regs
  import spa_pkg::*;
#(
  parameter int unsigned NM      = 8,
  parameter int unsigned LVL_W   = 3,
  parameter int unsigned FIELD_W = 4,
  parameter int unsigned DW      = 32,
  localparam int unsigned IDX_W  = $clog2(NM),
  localparam int unsigned PW     = NM * FIELD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             sel,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic [PW-1:0]    prio,
  output logic             rr_mode,
  output park_mode_e       park_mode,
  output logic [IDX_W-1:0] park_idx
);

  function automatic logic [DW-1:0] prio_mask_f();
    logic [DW-1:0] mk;
    mk = '0;
    for (int m = 0; m < int'(NM); m++) mk[m*FIELD_W +: LVL_W] = '1;
    return mk;
  endfunction

  function automatic logic [DW-1:0] prio_reset_f();
    logic [DW-1:0] v;
    v = '0;
    for (int m = 0; m < int'(NM); m++) v[m*FIELD_W +: LVL_W] = LVL_W'(m);
    return v;
  endfunction

  function automatic logic [DW-1:0] ctrl_mask_f();
    logic [DW-1:0] mk;
    mk = '0;
    mk[LOCK_POS] = 1'b1;
    mk[MODE_POS] = 1'b1;
    mk[PARK_MODE_POS +: 2] = 2'b11;
    mk[PARK_IDX_POS +: IDX_W] = '1;
    return mk;
  endfunction

  localparam logic [DW-1:0] PRIO_MASK  = prio_mask_f();
  localparam logic [DW-1:0] PRIO_RESET = prio_reset_f();
  localparam logic [DW-1:0] CTRL_MASK  = ctrl_mask_f();

  logic [DW-1:0] prio_q, ctrl_q;
  logic          locked;
  logic          wr_ok;

  assign locked = ctrl_q[LOCK_POS];
  assign wr_ok  = wr && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= PRIO_RESET;
      ctrl_q <= '0;
    end else if (wr_ok) begin
      if (reg_sel_e'(sel) == SEL_CTRL) ctrl_q <= wdata & CTRL_MASK;
      else                             prio_q <= wdata & PRIO_MASK;
    end
  end

  assign rdata     = (reg_sel_e'(sel) == SEL_CTRL) ? ctrl_q : prio_q;
  assign prio      = prio_q[PW-1:0];
  assign rr_mode   = ctrl_q[MODE_POS];
  assign park_mode = park_mode_e'(ctrl_q[PARK_MODE_POS +: 2]);
  assign park_idx  = ctrl_q[PARK_IDX_POS +: IDX_W];

  assert_lock_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr) |=> ($stable(ctrl_q) && $stable(prio_q)));

  assert_lock_sticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (((prio_q & ~PRIO_MASK) == '0) && ((ctrl_q & ~CTRL_MASK) == '0)));

endmodule

// File: rtl/spa_pick.sv
`timescale 1ns/1ps
module spa_pick #(
  parameter int unsigned NM      = 8,
  parameter int unsigned LVL_W   = 3,
  parameter int unsigned FIELD_W = 4,
  localparam int unsigned IDX_W  = $clog2(NM),
  localparam int unsigned PW     = NM * FIELD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NM-1:0]    req,
  input  logic [PW-1:0]    prio,
  input  logic             rr_mode,
  input  logic [IDX_W-1:0] last_idx,
  output logic             pick_valid,
  output logic [IDX_W-1:0] pick_idx
);

  localparam logic [LVL_W-1:0] LVL_MASKED = '1;

  logic [NM-1:0] elig;

  for (genvar m = 0; m < NM; m++) begin : g_elig
    assign elig[m] = req[m] && (prio[m*FIELD_W +: LVL_W] != LVL_MASKED);
  end

  // {found, index}: lowest level wins, strict compare keeps the lower index on ties
  function automatic logic [IDX_W:0] pick_fixed_f(input logic [NM-1:0] el,
                                                  input logic [PW-1:0] pr);
    logic [LVL_W-1:0] best;
    logic             found;
    logic [IDX_W-1:0] idx;
    best = LVL_MASKED; found = 1'b0; idx = '0;
    for (int m = 0; m < int'(NM); m++) begin
      if (el[m] && (pr[m*FIELD_W +: LVL_W] < best)) begin
        best  = pr[m*FIELD_W +: LVL_W];
        idx   = IDX_W'(m);
        found = 1'b1;
      end
    end
    return {found, idx};
  endfunction

  // {found, index}: first eligible master after the last winner, with wrap
  function automatic logic [IDX_W:0] pick_rr_f(input logic [NM-1:0] el,
                                               input logic [IDX_W-1:0] last);
    logic             found;
    logic [IDX_W-1:0] idx;
    int               j;
    found = 1'b0; idx = '0;
    for (int k = 1; k <= int'(NM); k++) begin
      j = int'(last) + k;
      if (j >= int'(NM)) j = j - int'(NM);
      if (!found && el[j]) begin
        found = 1'b1;
        idx   = IDX_W'(j);
      end
    end
    return {found, idx};
  endfunction

  logic [IDX_W:0] fixed_res, rr_res, sel_res;

  assign fixed_res  = pick_fixed_f(elig, prio);
  assign rr_res     = pick_rr_f(elig, last_idx);
  assign sel_res    = rr_mode ? rr_res : fixed_res;
  assign pick_valid = sel_res[IDX_W];
  assign pick_idx   = sel_res[IDX_W-1:0];

  assert_pick_requested_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> (req[pick_idx] && (prio[pick_idx*FIELD_W +: LVL_W] != LVL_MASKED)));

  assert_pick_when_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> (pick_valid || ($countones(req & ~elig) == $countones(req))));

endmodule

// File: rtl/spa_owner.sv
`timescale 1ns/1ps
module spa_owner
  import spa_pkg::*;
#(
  parameter int unsigned NM     = 8,
  localparam int unsigned IDX_W = $clog2(NM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pick_valid,
  input  logic [IDX_W-1:0] pick_idx,
  input  logic             xfer_busy,
  input  park_mode_e       park_mode,
  input  logic [IDX_W-1:0] park_idx,
  output logic             owner_valid,
  output logic [IDX_W-1:0] owner_idx,
  output logic [IDX_W-1:0] last_idx
);

  logic             hold_now;   // owner keeps the port this edge
  logic             idle_now;   // boundary cycle with no eligible requester
  logic             nxt_valid;
  logic [IDX_W-1:0] nxt_idx;
  logic [IDX_W-1:0] nxt_last;

  assign hold_now = owner_valid && xfer_busy;
  assign idle_now = !hold_now && !pick_valid;

  always_comb begin
    nxt_valid = owner_valid;
    nxt_idx   = owner_idx;
    nxt_last  = last_idx;
    if (!hold_now) begin
      if (pick_valid) begin
        nxt_valid = 1'b1;
        nxt_idx   = pick_idx;
        nxt_last  = pick_idx;
      end else begin
        unique case (park_mode)
          PARK_ON_FIXED: begin nxt_valid = 1'b1; nxt_idx = park_idx; end
          PARK_ON_LAST:  begin nxt_valid = 1'b1; nxt_idx = last_idx; end
          default:       begin nxt_valid = 1'b0; end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_valid <= 1'b1;
      owner_idx   <= '0;
      last_idx    <= IDX_W'(NM - 1);
    end else begin
      owner_valid <= nxt_valid;
      owner_idx   <= nxt_idx;
      last_idx    <= nxt_last;
    end
  end

  assert_hold_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_now |=> (owner_valid && (owner_idx == $past(owner_idx))));

  assert_winner_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_now && pick_valid) |=> (owner_valid && (owner_idx == $past(pick_idx))
                                   && (last_idx == $past(pick_idx))));

  assert_park_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_now && park_mode == PARK_ON_FIXED) |=> (owner_valid && (owner_idx == $past(park_idx))));

  assert_park_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_now && park_mode == PARK_ON_LAST) |=> (owner_valid && (owner_idx == $past(last_idx))));

  assert_no_park_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_now && (park_mode == PARK_NONE || park_mode == PARK_NONE_ALT)) |=> !owner_valid);

endmodule

// File: rtl/slave_port_arbiter.sv
`timescale 1ns/1ps
module slave_port_arbiter
  import spa_pkg::*;
#(
  parameter int unsigned NM      = 8,
  parameter int unsigned LVL_W   = 3,
  parameter int unsigned FIELD_W = 4,
  parameter int unsigned DW      = 32,
  localparam int unsigned IDX_W  = $clog2(NM),
  localparam int unsigned PW     = NM * FIELD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NM-1:0]    req,
  input  logic             xfer_busy,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic [NM-1:0]    gnt,
  output logic [IDX_W-1:0] gnt_idx,
  output logic             gnt_valid
);

  logic [PW-1:0]    prio;
  logic             rr_mode;
  park_mode_e       park_mode;
  logic [IDX_W-1:0] park_idx;
  logic             pick_valid;
  logic [IDX_W-1:0] pick_idx;
  logic             owner_valid;
  logic [IDX_W-1:0] owner_idx;
  logic [IDX_W-1:0] last_idx;

  spa_regs #(.NM(NM), .LVL_W(LVL_W), .FIELD_W(FIELD_W), .DW(DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .sel      (reg_sel),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .prio     (prio),
    .rr_mode  (rr_mode),
    .park_mode(park_mode),
    .park_idx (park_idx)
  );

  spa_pick #(.NM(NM), .LVL_W(LVL_W), .FIELD_W(FIELD_W)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .prio      (prio),
    .rr_mode   (rr_mode),
    .last_idx  (last_idx),
    .pick_valid(pick_valid),
    .pick_idx  (pick_idx)
  );

  spa_owner #(.NM(NM)) u_owner (
    .clk        (clk),
    .rst_n      (rst_n),
    .pick_valid (pick_valid),
    .pick_idx   (pick_idx),
    .xfer_busy  (xfer_busy),
    .park_mode  (park_mode),
    .park_idx   (park_idx),
    .owner_valid(owner_valid),
    .owner_idx  (owner_idx),
    .last_idx   (last_idx)
  );

  for (genvar m = 0; m < NM; m++) begin : g_gnt
    assign gnt[m] = owner_valid && (owner_idx == IDX_W'(m));
  end

  assign gnt_idx   = owner_valid ? owner_idx : '0;
  assign gnt_valid = owner_valid;

  assert_grant_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && (gnt_valid == (gnt != '0)) && (!gnt_valid || gnt[gnt_idx]));

endmodule

// File: tb/slave_port_arbiter_tb_top.sv
`timescale 1ns/1ps
module slave_port_arbiter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  req = '0;
  logic        xfer_busy = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  gnt;
  logic [2:0]  gnt_idx;
  logic        gnt_valid;

  int total = 0;
  int bad = 0;
  int wd = 0;

  // bench model state
  logic [31:0] m_prio, m_ctrl;
  logic        m_valid;
  logic [2:0]  m_idx, m_last;

  always #2.5 clk = ~clk;

  slave_port_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .xfer_busy(xfer_busy),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .gnt(gnt), .gnt_idx(gnt_idx), .gnt_valid(gnt_valid)
  );

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      total++; bad++;
      $display("FAIL R8 watchdog: cycles=%0d expected<=%0d", wd, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [2:0] lvl(input logic [31:0] p, input int m);
    return 3'((p >> (4 * m)) & 32'h7);
  endfunction

  // returns {found, idx}
  function automatic logic [3:0] ref_pick(input logic [7:0] r);
    if (m_ctrl[8]) begin
      for (int s = 0; s < 8; s++) begin
        int i;
        i = (int'(m_last) + 1 + s) % 8;
        if (r[i] && lvl(m_prio, i) != 3'd7) return {1'b1, 3'(i)};
      end
    end else begin
      for (int l = 0; l < 7; l++)
        for (int m = 0; m < 8; m++)
          if (r[m] && lvl(m_prio, m) == 3'(l)) return {1'b1, 3'(m)};
    end
    return 4'b0;
  endfunction

  task automatic model_step();
    logic [3:0] p;
    if (!(m_valid && xfer_busy)) begin
      p = ref_pick(req);
      if (p[3]) begin
        m_valid = 1'b1; m_idx = p[2:0]; m_last = p[2:0];
      end else if (m_ctrl[5:4] == 2'b00) begin
        m_valid = 1'b1; m_idx = m_ctrl[2:0];
      end else if (m_ctrl[5:4] == 2'b01) begin
        m_valid = 1'b1; m_idx = m_last;
      end else begin
        m_valid = 1'b0;
      end
    end
    if (reg_wr && !m_ctrl[31]) begin
      if (reg_sel) m_ctrl = reg_wdata & 32'h8000_0137;
      else         m_prio = reg_wdata & 32'h7777_7777;
    end
  endtask

  task automatic check_outputs(input string tag);
    logic [2:0] ei;
    logic [7:0] eg;
    ei = m_valid ? m_idx : 3'd0;
    eg = m_valid ? (8'd1 << m_idx) : 8'd0;
    total++;
    if (gnt_valid !== m_valid || gnt_idx !== ei) begin
      bad++;
      $display("FAIL %s grant: valid/idx=%0b/%0d expected %0b/%0d req=%h",
               tag, gnt_valid, gnt_idx, m_valid, ei, req);
    end
    total++;
    if (gnt !== eg) begin
      bad++;
      $display("FAIL R12 one-hot: gnt=%h expected %h", gnt, eg);
    end
  endtask

  task automatic cycle(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_outputs(tag);
  endtask

  task automatic write_reg(input logic sel, input logic [31:0] d, input string tag);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    cycle(tag);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic read_check(input logic sel, input string tag);
    logic [31:0] e;
    reg_sel = sel;
    #1;
    e = sel ? m_ctrl : m_prio;
    total++;
    if (reg_rdata !== e) begin
      bad++;
      $display("FAIL %s read sel=%0b: got %h expected %h", tag, sel, reg_rdata, e);
    end
  endtask

  initial begin
    m_prio = 32'h7654_3210; m_ctrl = '0;
    m_valid = 1'b1; m_idx = 3'd0; m_last = 3'd7;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state: registers and parked grant on master 0
    read_check(1'b0, "R1");
    read_check(1'b1, "R1");
    check_outputs("R9");

    // reset priorities: level m for master m, master 7 masked
    req = 8'hFF; cycle("R4");
    req = 8'h80; cycle("R5");
    req = 8'h00; cycle("R9");

    // reserved bits dropped on both words
    write_reg(1'b0, 32'hFFFF_FFFF, "R2"); read_check(1'b0, "R2");
    write_reg(1'b1, 32'h7FFF_FFFF, "R2"); read_check(1'b1, "R2");
    req = 8'hFF; cycle("R5"); cycle("R5");
    req = 8'h00;

    // fixed-mode sweep with ties and a masked master, no parking
    write_reg(1'b1, 32'h0000_0020, "R11");
    write_reg(1'b0, 32'h2103_7012, "R1"); read_check(1'b0, "R1");
    for (int r = 0; r < 256; r++) begin
      req = 8'(r);
      cycle((r == 8) ? "R5" : "R4");
      req = 8'h00;
      cycle("R11");
    end

    // round-robin sweep, each pattern held for several rotations
    write_reg(1'b1, 32'h0000_0120, "R6");
    for (int r = 0; r < 256; r++) begin
      req = 8'(r);
      cycle("R6"); cycle("R6"); cycle("R6");
    end
    req = 8'h00; cycle("R11");

    // hold while busy in both modes
    for (int md = 0; md < 2; md++) begin
      write_reg(1'b1, (md == 1) ? 32'h0000_0120 : 32'h0000_0020, "R7");
      req = 8'h01; cycle("R8");
      xfer_busy = 1'b1; req = 8'h24;
      cycle("R7"); cycle("R7"); cycle("R7");
      xfer_busy = 1'b0; cycle("R8"); cycle("R8");
      req = 8'h00; cycle("R11");
      xfer_busy = 1'b1; cycle("R11");
      xfer_busy = 1'b0;
    end

    // park on a programmed master
    write_reg(1'b1, 32'h0000_0005, "R9");
    cycle("R9");
    req = 8'h20; check_outputs("R8"); cycle("R8");
    req = 8'h04; cycle("R8");
    req = 8'h00; cycle("R9"); cycle("R9");
    for (int p = 0; p < 8; p++) begin
      write_reg(1'b1, 32'(p), "R9"); cycle("R9");
    end

    // park on the last winner
    write_reg(1'b1, 32'h0000_0010, "R10");
    req = 8'h40; cycle("R10");
    req = 8'h00; cycle("R10"); cycle("R10");
    req = 8'h02; cycle("R10");
    req = 8'h00; cycle("R10");

    // no parking with the spare encoding
    write_reg(1'b1, 32'h0000_0030, "R11");
    cycle("R11"); cycle("R11");

    // lock: later writes to either word have no effect
    write_reg(1'b1, 32'h8000_0005, "R3");
    cycle("R3");
    write_reg(1'b0, 32'h0000_0000, "R3");
    write_reg(1'b1, 32'h0000_0020, "R3");
    read_check(1'b0, "R3");
    read_check(1'b1, "R3");
    cycle("R3");
    req = 8'h08; cycle("R3");
    req = 8'h00; cycle("R3");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule